// File: doc/BRIEF.md
# NAND Flash PIO Front End

This block lets a host drive an 8-bit NAND flash device one byte at a time through a small register bus. The host writes a command byte, an address byte or a data byte to one of three queue registers. Each write becomes a tagged entry in a short in-order write buffer. A sequencer takes entries from the buffer and turns each one into a pin-level cycle. Command entries assert the command-latch line, address entries assert the address-latch line, and data entries assert neither. In every such cycle the write strobe is held low for a programmable number of clocks.

Reads are split-phase. The host posts a request by writing any value to the read-request register, and that request travels through the same buffer as the writes. The sequencer pulses the read strobe and samples the device bus on its last low clock. It then stores the byte and raises a sticky ready flag. The host polls or takes an interrupt on that flag, collects the byte from the read-data register, and writes a one to clear the flag.

The status register reports the buffer level, pending page traffic and the synchronized ready/busy pin. Sticky event flags, with a mask, drive a single interrupt line.

Top module: `nand_pio_frontend`

## Requirements
- R1: After reset the device pins are idle: command-latch and address-latch low, both strobes high, bus not driven. Status (offset 1) reads 0x11, meaning buffer empty and device ready with the ready/busy pin high. Event flags (offset 2) read 0 and the interrupt output is low.
- R2: A write to offset 4 produces one cycle with the command-latch line high and the written byte on the bus. In that cycle the write strobe is low for exactly (write delay + 1) clocks. The write delay is control bits 3:0.
- R3: A write to offset 5 produces the same kind of cycle with the address-latch line high instead of the command-latch line.
- R4: A write to offset 6 produces a write-strobe cycle with both latch lines low. Status bit 2 is set while any data byte is queued or in flight. Event bit 4 is set once the last such byte has completed.
- R5: A write of any value to offset 7 produces one read-strobe cycle. The read strobe is low for (read delay + 1) clocks, where the read delay is control bits 7:4. The device byte is sampled on the last low clock and appears at offset 8, and event bit 3 is set.
- R6: Queued entries execute strictly in the order written. The buffer holds 4 entries. Status bit 1 is set when the buffer is full and status bit 4 when it is empty.
- R7: A queue write while the buffer is full is dropped and sets event bit 1.
- R8: Event bit 2 is set when the buffer leaves the full state.
- R9: Writing to offset 2 clears exactly the event bits written as one. Zero bits have no effect, and 0xFFFF clears every flag.
- R10: Status bit 0 follows the ready/busy pin through two synchronizing flops. A low-to-high change of that bit sets event bit 0.
- R11: The interrupt output is high exactly when some event flag is set and its bit in the mask register (offset 3) is one. A mask of zero keeps it low.
- R12: The control register (offset 0) reads back bits 9:0 as written. Bit 8 is the bus-width flag and bit 9 is the page-size flag (1 = 512 bytes). Bits 15:10 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Register write strobe |
| hostAddr | input | 4 | Register offset for write and read |
| hostWrData | input | 16 | Register write data |
| hostRdData | output | 16 | Register read data for hostAddr (combinational) |
| irq | output | 1 | Masked OR of event flags |
| nandCle | output | 1 | Command-latch enable |
| nandAle | output | 1 | Address-latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDataOut | output | 8 | Bus value to the device |
| nandDataOe | output | 1 | Bus output enable |
| nandDataIn | input | 8 | Bus value from the device |
| nandRbN | input | 1 | Device ready/busy pin, high when ready |

## Verification
The bench uses the default parameters: a 4-entry buffer and 4-bit delay fields. With these values, five back-to-back queue writes are enough to fill the buffer while the first entry is still running at the slowest 16-clock strobe, so the full, overflow and leave-full corners can be reached in a few dozen clocks. The 4-bit fields also keep every delay from 0 to 15 within reach of the random batches, so each cycle's strobe width can be checked against a value the bench predicts.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_DATA = 2'd2,
    OP_READ = 2'd3
  } opKind_e;

  typedef struct packed {
    opKind_e    kind;
    logic [7:0] byteVal;
  } fifoEntry_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic pop;
    logic capture;
    logic busyWr;
    logic busyRd;
  } seqStrobe_t;

  localparam logic [3:0] REG_CTRL   = 4'h0;
  localparam logic [3:0] REG_STATUS = 4'h1;
  localparam logic [3:0] REG_EVENT  = 4'h2;
  localparam logic [3:0] REG_MASK   = 4'h3;
  localparam logic [3:0] REG_CMD    = 4'h4;
  localparam logic [3:0] REG_ADDR   = 4'h5;
  localparam logic [3:0] REG_WDATA  = 4'h6;
  localparam logic [3:0] REG_RDREQ  = 4'h7;
  localparam logic [3:0] REG_RDATA  = 4'h8;

endpackage

// File: rtl/nfc_datapath.sv
module nfc_datapath
  import nfc_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DLY_W  = 4,
  parameter int HOST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [3:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  output logic              irq,
  input  logic [7:0]        nandDataIn,
  input  logic              nandRbN,
  input  seqStrobe_t        strobe,
  output fifoEntry_t        headEntry,
  output logic              fifoEmpty,
  output logic [DLY_W-1:0]  wrDelay,
  output logic [DLY_W-1:0]  rdDelay
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CTRL_W = 2 * DLY_W + 2;
  localparam int EV_W   = 5;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [EV_W-1:0]   evFlags, evMask, evSet, evClr;
  logic [7:0]        rdByte;

  fifoEntry_t        fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCount, dataQueued, readQueued;
  logic              fifoFull, isQueueWr, doPush;
  opKind_e           newKind;

  logic [1:0]        rbSync;
  logic              notBusy, notBusyPrev, fullPrev, pgWr, pgWrPrev, pgRd;
  logic              unusedHostBits;

  assign unusedHostBits = ^hostWrData[HOST_W-1:CTRL_W];

  assign wrDelay   = ctrlReg[DLY_W-1:0];
  assign rdDelay   = ctrlReg[2*DLY_W-1:DLY_W];
  assign fifoFull  = (fifoCount == FULL_CNT);
  assign fifoEmpty = (fifoCount == '0);
  assign headEntry = fifoMem[rdPtr];
  assign doPush    = isQueueWr && !fifoFull;

  always_comb begin
    isQueueWr = 1'b0;
    newKind   = OP_CMD;
    if (hostWrEn) begin
      case (hostAddr)
        REG_CMD:   begin isQueueWr = 1'b1; newKind = OP_CMD;  end
        REG_ADDR:  begin isQueueWr = 1'b1; newKind = OP_ADDR; end
        REG_WDATA: begin isQueueWr = 1'b1; newKind = OP_DATA; end
        REG_RDREQ: begin isQueueWr = 1'b1; newKind = OP_READ; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      fifoMem[wrPtr] <= '{kind: newKind, byteVal: hostWrData[7:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      fifoCount  <= '0;
      dataQueued <= '0;
      readQueued <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      fifoCount <= fifoCount + CNT_W'(doPush) - CNT_W'(strobe.pop);
      dataQueued <= dataQueued
                    + CNT_W'(doPush && newKind == OP_DATA)
                    - CNT_W'(strobe.pop && headEntry.kind == OP_DATA);
      readQueued <= readQueued
                    + CNT_W'(doPush && newKind == OP_READ)
                    - CNT_W'(strobe.pop && headEntry.kind == OP_READ);
    end
  end

  assign pgWr    = (dataQueued != '0) || strobe.busyWr;
  assign pgRd    = (readQueued != '0) || strobe.busyRd;
  assign notBusy = rbSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbSync      <= 2'b11;
      notBusyPrev <= 1'b1;
      fullPrev    <= 1'b0;
      pgWrPrev    <= 1'b0;
    end else begin
      rbSync      <= {rbSync[0], nandRbN};
      notBusyPrev <= notBusy;
      fullPrev    <= fifoFull;
      pgWrPrev    <= pgWr;
    end
  end

  always_comb begin
    evSet    = '0;
    evSet[0] = notBusy && !notBusyPrev;
    evSet[1] = isQueueWr && fifoFull;
    evSet[2] = fullPrev && !fifoFull;
    evSet[3] = strobe.capture;
    evSet[4] = pgWrPrev && !pgWr;
    evClr    = (hostWrEn && hostAddr == REG_EVENT) ? hostWrData[EV_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      evMask  <= '0;
      evFlags <= '0;
      rdByte  <= '0;
    end else begin
      if (hostWrEn && hostAddr == REG_CTRL) ctrlReg <= hostWrData[CTRL_W-1:0];
      if (hostWrEn && hostAddr == REG_MASK) evMask  <= hostWrData[EV_W-1:0];
      if (strobe.capture) rdByte <= nandDataIn;
      evFlags <= (evFlags & ~evClr) | evSet;
    end
  end

  assign irq = |(evFlags & evMask);

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      REG_CTRL:   hostRdData[CTRL_W-1:0] = ctrlReg;
      REG_STATUS: hostRdData[4:0] = {fifoEmpty, pgRd, pgWr, fifoFull, notBusy};
      REG_EVENT:  hostRdData[EV_W-1:0] = evFlags;
      REG_MASK:   hostRdData[EV_W-1:0] = evMask;
      REG_RDATA:  hostRdData[7:0] = rdByte;
      default:    ;
    endcase
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isQueueWr && fifoFull && !strobe.pop) |=> (fifoCount == $past(fifoCount)));

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (fifoCount != '0));

  // R5
  rd_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (evFlags[3] && rdByte == $past(nandDataIn)));

  // R10
  ready_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(notBusy) |=> evFlags[0]);

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  fifoEntry_t       headEntry,
  input  logic [DLY_W-1:0] wrDelay,
  input  logic [DLY_W-1:0] rdDelay,
  output seqStrobe_t       strobe,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandDataOut,
  output logic             nandDataOe
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACTIVE, S_HOLD} seqState_e;

  seqState_e        state;
  fifoEntry_t       cur;
  logic [DLY_W-1:0] lowCnt;
  logic             engaged, isRead;

  assign engaged = (state != S_IDLE);
  assign isRead  = (cur.kind == OP_READ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cur    <= '{kind: OP_CMD, byteVal: 8'h00};
      lowCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (!fifoEmpty) begin
          cur   <= headEntry;
          state <= S_SETUP;
        end
        S_SETUP: begin
          lowCnt <= isRead ? rdDelay : wrDelay;
          state  <= S_ACTIVE;
        end
        S_ACTIVE: begin
          if (lowCnt == '0) state <= S_HOLD;
          else lowCnt <= lowCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.pop     = (state == S_IDLE) && !fifoEmpty;
    strobe.capture = (state == S_ACTIVE) && (lowCnt == '0) && isRead;
    strobe.busyWr  = engaged && (cur.kind == OP_DATA);
    strobe.busyRd  = engaged && isRead;
  end

  assign nandCle     = engaged && (cur.kind == OP_CMD);
  assign nandAle     = engaged && (cur.kind == OP_ADDR);
  assign nandDataOe  = engaged && !isRead;
  assign nandDataOut = nandDataOe ? cur.byteVal : 8'h00;
  assign nandWeN     = !((state == S_ACTIVE) && !isRead);
  assign nandReN     = !((state == S_ACTIVE) && isRead);

  // R4
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> (nandDataOe && $past(nandDataOe)));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> (nandDataOe && $stable(nandDataOut)));

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |-> !nandDataOe);

  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

endmodule

// File: rtl/nand_pio_frontend.sv
module nand_pio_frontend
  import nfc_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DLY_W  = 4,
  parameter int HOST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [3:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  output logic              irq,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDataOut,
  output logic              nandDataOe,
  input  logic [7:0]        nandDataIn,
  input  logic              nandRbN
);

  seqStrobe_t       strobe;
  fifoEntry_t       headEntry;
  logic             fifoEmpty;
  logic [DLY_W-1:0] wrDelay, rdDelay;

  nfc_datapath #(.DEPTH(DEPTH), .DLY_W(DLY_W), .HOST_W(HOST_W)) uDp (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq),
    .nandDataIn(nandDataIn), .nandRbN(nandRbN), .strobe(strobe),
    .headEntry(headEntry), .fifoEmpty(fifoEmpty),
    .wrDelay(wrDelay), .rdDelay(rdDelay)
  );

  nfc_seq #(.DLY_W(DLY_W)) uSeq (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .headEntry(headEntry),
    .wrDelay(wrDelay), .rdDelay(rdDelay), .strobe(strobe),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDataOut(nandDataOut), .nandDataOe(nandDataOe)
  );

endmodule

// File: tb/nand_pio_frontend_test.sv
module nand_pio_frontend_test;
  import nfc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN, hostWrEn, irq;
  logic [3:0]  hostAddr;
  logic [15:0] hostWrData, hostRdData;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDataOe, nandRbN;
  logic [7:0]  nandDataOut, nandDataIn;

  always #5 clk = ~clk;

  nand_pio_frontend uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irq(irq),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDataOut(nandDataOut), .nandDataOe(nandDataOe),
    .nandDataIn(nandDataIn), .nandRbN(nandRbN)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // pin monitor: logs each completed strobe cycle
  int logKind [512];
  int logByte [512];
  int logWidth[512];
  int logN = 0;
  int wCnt = 0, rCnt = 0, wKind = 0, wByte = 0, rByte = 0;

  always @(negedge clk) begin
    if (!nandWeN) begin
      wCnt++;
      wKind = nandCle ? 0 : (nandAle ? 1 : 2);
      wByte = int'(nandDataOut);
    end else if (wCnt != 0) begin
      if (logN < 512) begin
        logKind[logN] = wKind; logByte[logN] = wByte; logWidth[logN] = wCnt;
        logN++;
      end
      wCnt = 0;
    end
    if (!nandReN) begin
      rCnt++;
      rByte = int'(nandDataIn);
    end else if (rCnt != 0) begin
      if (logN < 512) begin
        logKind[logN] = 3; logByte[logN] = rByte; logWidth[logN] = rCnt;
        logN++;
      end
      rCnt = 0;
    end
  end

  int expKind [512];
  int expByte [512];
  int expWidth[512];
  int expN = 0;

  function automatic int strobeWidth(input int dly);
    return dly + 1;
  endfunction

  function automatic string kindTag(input int k);
    case (k)
      0: return "R2 cmd";
      1: return "R3 addr";
      2: return "R4 data";
      default: return "R5 read";
    endcase
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectOp(input int k, input int b, input int w);
    if (expN < 512) begin
      expKind[expN] = k; expByte[expN] = b; expWidth[expN] = w;
      expN++;
    end
  endtask

  // tasks start and end at a negedge
  task automatic hostWr(input logic [3:0] a, input logic [15:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [3:0] a, output logic [15:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int g = 0; g < 2000; g++) begin
      hostRd(REG_STATUS, s);
      if (s[4] && !s[2] && !s[3]) break;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic checkLog();
    chkEq("R6 cycle count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chkEq({kindTag(expKind[i]), " kind (R6 order)"}, logKind[i], expKind[i]);
      chkEq({kindTag(expKind[i]), " byte"}, logByte[i], expByte[i]);
      chkEq({kindTag(expKind[i]), " strobe width"}, logWidth[i], expWidth[i]);
    end
    logN = 0;
    expN = 0;
  endtask

  logic [15:0] rv;

  initial begin
    rstN = 1'b0; hostWrEn = 1'b0; hostAddr = '0; hostWrData = '0;
    nandDataIn = '0; nandRbN = 1'b1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkEq("R1 cle", int'(nandCle), 0);
    chkEq("R1 ale", int'(nandAle), 0);
    chkEq("R1 weN", int'(nandWeN), 1);
    chkEq("R1 reN", int'(nandReN), 1);
    chkEq("R1 oe", int'(nandDataOe), 0);
    hostRd(REG_STATUS, rv); chkEq("R1 status", int'(rv), 'h11);
    hostRd(REG_EVENT, rv);  chkEq("R1 events", int'(rv), 0);
    chkEq("R1 irq", int'(irq), 0);

    // R12 control readback
    hostWr(REG_CTRL, 16'hFFFF);
    hostRd(REG_CTRL, rv); chkEq("R12 ctrl readback", int'(rv), 'h03FF);

    // R6 R7 R8: fill the buffer at the slowest strobe
    hostWr(REG_CTRL, 16'h00FF);
    for (int i = 0; i < 5; i++) begin
      hostWr(REG_CMD, 16'(8'hA0 + i));
      expectOp(0, 'hA0 + i, strobeWidth(15));
    end
    hostRd(REG_STATUS, rv);
    chkEq("R6 full bit", int'(rv[1]), 1);
    chkEq("R6 empty bit", int'(rv[4]), 0);
    hostWr(REG_CMD, 16'h00A5);
    hostRd(REG_EVENT, rv); chkEq("R7 overflow flag", int'(rv[1]), 1);
    waitIdle();
    hostRd(REG_EVENT, rv); chkEq("R8 leave-full flag", int'(rv[2]), 1);
    checkLog();

    // R9 write-one-to-clear
    hostRd(REG_EVENT, rv); chkEq("R9 flags before clear", int'(rv), 'h06);
    hostWr(REG_EVENT, 16'h0002);
    hostRd(REG_EVENT, rv); chkEq("R9 clear one bit", int'(rv), 'h04);
    hostWr(REG_EVENT, 16'h0000);
    hostRd(REG_EVENT, rv); chkEq("R9 zero write no effect", int'(rv), 'h04);
    hostWr(REG_EVENT, 16'hFFFF);
    hostRd(REG_EVENT, rv); chkEq("R9 clear all", int'(rv), 0);

    // R4 data write pending and done
    hostWr(REG_CTRL, 16'h0023);
    hostWr(REG_WDATA, 16'h005A);
    expectOp(2, 'h5A, strobeWidth(3));
    hostRd(REG_STATUS, rv); chkEq("R4 write pending", int'(rv[2]), 1);
    waitIdle();
    hostRd(REG_EVENT, rv); chkEq("R4 write done flag", int'(rv[4]), 1);
    checkLog();
    hostWr(REG_EVENT, 16'hFFFF);

    // R10 ready/busy synchronizer and event
    nandRbN = 1'b0;
    repeat (3) @(negedge clk);
    hostRd(REG_STATUS, rv); chkEq("R10 busy seen", int'(rv[0]), 0);
    hostRd(REG_EVENT, rv);  chkEq("R10 no event on fall", int'(rv[0]), 0);
    nandRbN = 1'b1;
    @(negedge clk);
    hostRd(REG_STATUS, rv); chkEq("R10 one flop delay", int'(rv[0]), 0);
    @(negedge clk);
    hostRd(REG_STATUS, rv); chkEq("R10 two flop delay", int'(rv[0]), 1);
    @(negedge clk);
    hostRd(REG_EVENT, rv);  chkEq("R10 ready event", int'(rv[0]), 1);

    // R11 masking
    hostWr(REG_MASK, 16'h0000); chkEq("R11 mask zero", int'(irq), 0);
    hostWr(REG_MASK, 16'h0001); chkEq("R11 mask enabled", int'(irq), 1);
    hostWr(REG_MASK, 16'h0002); chkEq("R11 other bit masked", int'(irq), 0);
    hostWr(REG_EVENT, 16'hFFFF);
    hostWr(REG_MASK, 16'h0000);

    // random batches
    for (int b = 0; b < 3; b++) begin
      int wd, rd;
      wd = int'($urandom % 16);
      rd = int'($urandom % 16);
      hostWr(REG_CTRL, 16'(((b % 2) << 9) | (rd << 4) | wd));
      for (int k = 0; k < 20; k++) begin
        int kind, v;
        for (int g = 0; g < 500; g++) begin
          hostRd(REG_STATUS, rv);
          if (!rv[1]) break;
          @(negedge clk);
        end
        kind = int'($urandom % 4);
        v    = int'($urandom % 256);
        if (kind < 3) begin
          hostWr(REG_CMD + 4'(kind), 16'(v));
          expectOp(kind, v, strobeWidth(wd));
        end else begin
          nandDataIn = 8'(v);
          hostWr(REG_RDREQ, 16'h0000);
          expectOp(3, v, strobeWidth(rd));
          for (int g = 0; g < 500; g++) begin
            hostRd(REG_EVENT, rv);
            if (rv[3]) break;
            @(negedge clk);
          end
          chkEq("R5 ready flag", int'(rv[3]), 1);
          hostRd(REG_RDATA, rv); chkEq("R5 read byte", int'(rv), v);
          hostWr(REG_EVENT, 16'h0008);
          hostRd(REG_EVENT, rv); chkEq("R9 ready cleared", int'(rv[3]), 0);
        end
      end
      waitIdle();
      checkLog();
      hostWr(REG_EVENT, 16'hFFFF);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule